// File: doc/BRIEF.md
# Poll-Gated Transmit Sequencer for a Secondary Link Station

This block decides when a secondary station on a bit-oriented synchronous link may transmit, in normal response mode. Software arms a send request at any time. The request waits until the primary station hands over permission. The block then asks the frame transmitter to send the frame. After an information frame has gone out, it keeps the transmit FIFO locked until the primary's acknowledgement arrives. It sorts that acknowledgement into "accepted" or "send again" and reports the result as a one-cycle interrupt.

The block sits between three parties. The CPU issues command strobes. The frame receiver presents one decoded frame per `rx_valid` strobe, giving its type, poll bit and received sequence number. The frame transmitter takes a start pulse with a frame descriptor and answers with `tx_done`. The block contains a recovery timer, but only software starts or stops it; the block never starts it on its own.

Top module: `sec_poll_tx_ctrl`

## Requirements
- R1: After reset, `fifo_en` is 1, `tx_start` is 0 and all three interrupt outputs are 0.
- R2: `cmd_send_info` only arms a pending information frame. Without a qualifying poll, no information frame starts, and received frames with `rx_poll`=0 never start one.
- R3: In idle with an information frame pending, a received RR (`rx_kind`=1) or I-frame (`rx_kind`=0) with `rx_poll`=1 raises `tx_start` for exactly one cycle, one cycle after the strobe. It presents `tx_kind`=0, `tx_final`=1 and `tx_ns` equal to the current send sequence number, which is 0 after reset. A polled REJ (`rx_kind`=2) or RNR (`rx_kind`=3) starts no information frame.
- R4: On the cycle after `tx_done` for an information frame, `fifo_en` goes to 0. It stays 0 until an acknowledgement is classified.
- R5: While locked, an RR, I or RNR frame with `rx_nr` = sent N(S)+1 mod 8 is a positive acknowledgement. It re-enables `fifo_en`, pulses `irq_all_sent` for one cycle, advances the send sequence number by 1 mod 8 and clears the pending request.
- R6: While locked, a REJ (any `rx_nr`) or a frame with `rx_nr` equal to the sent N(S) is a repeat request. It re-enables `fifo_en` and pulses `irq_repeat` for one cycle. The sequence number is unchanged, and the next poll resends with the same `tx_ns`.
- R7: `cmd_send_transp` arms a transparent frame (`tx_kind`=1). It starts on any I-frame, or on any supervisory frame that has `rx_poll`=1, and carries `tx_final` equal to the granting frame's poll bit. After it is sent, `fifo_en` stays 1. A pending information frame wins when both frame types are granted.
- R8: A frame with `rx_poll`=1 that arrives while nothing is pending starts an RR response (`tx_kind`=2, `tx_final`=1). `fifo_en` stays 1 throughout.
- R9: A timer started by `cmd_tmr_start` expires `tmr_limit`+1 cycles after the start strobe is sampled. If the block is still locked at that point, `irq_timeout` pulses and the FIFO stays locked, ignoring acknowledgements, until `cmd_tx_reset`. `cmd_tx_reset` re-enables the FIFO and drops all pending requests.
- R10: The timer runs only after `cmd_tmr_start`. With no start command, or after `cmd_tmr_stop`, a locked station raises no `irq_timeout`.
- R11: Permission frames that arrive while a frame is being sent or awaits acknowledgement start nothing. While locked, sequence numbers other than N(S) and N(S)+1 (in a non-REJ frame) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_send_info | input | 1 | Strobe: arm an information frame |
| cmd_send_transp | input | 1 | Strobe: arm a transparent frame |
| cmd_tx_reset | input | 1 | Strobe: drop pending requests, unlock FIFO |
| cmd_tmr_start | input | 1 | Strobe: start recovery timer from zero |
| cmd_tmr_stop | input | 1 | Strobe: stop recovery timer |
| tmr_limit | input | TMR_W | Recovery timer count limit |
| rx_valid | input | 1 | One-cycle strobe: decoded frame present |
| rx_kind | input | 2 | Received type: 0 I, 1 RR, 2 REJ, 3 RNR |
| rx_poll | input | 1 | Poll bit of the received frame |
| rx_nr | input | SEQ_W | Received N(R) |
| tx_done | input | 1 | Transmitter finished the started frame |
| tx_start | output | 1 | One-cycle request to the transmitter |
| tx_kind | output | 2 | Frame to send: 0 information, 1 transparent, 2 RR response |
| tx_final | output | 1 | Final bit for the started frame |
| tx_ns | output | SEQ_W | N(S) for the started information frame |
| fifo_en | output | 1 | Transmit FIFO enable |
| irq_all_sent | output | 1 | Pulse: frame positively acknowledged |
| irq_repeat | output | 1 | Pulse: frame must be repeated |
| irq_timeout | output | 1 | Pulse: recovery timer expired while locked |

## Verification
The assertions rely on the following input behaviour:
- `rx_valid` and every command are single-cycle strobes.
- `tx_done` comes only after a `tx_start` and before the next frame.
- `tmr_limit` is at least 1 and holds steady while the timer runs.

The bench drives every input through tasks that raise a strobe for exactly one cycle. It issues `tx_done` only after checking that a start was observed. It changes `tmr_limit` only while the timer is idle. Random rounds pick frame types, poll bits and acknowledgement forms from these legal sets only.

// File: rtl/sec_poll_pkg.sv
package sec_poll_pkg;
  parameter int SEQ_W = 3;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [1:0] {RX_I = 2'd0, RX_RR = 2'd1, RX_REJ = 2'd2, RX_RNR = 2'd3} rx_kind_e;
  typedef enum logic [1:0] {TX_INFO = 2'd0, TX_TRANSP = 2'd1, TX_RRESP = 2'd2} tx_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_STUCK} st_e;
  typedef enum logic [1:0] {ACK_NONE, ACK_POS, ACK_REP} ack_e;

  function automatic seq_t seq_next(seq_t s);
    return s + seq_t'(1);
  endfunction

  // permission for an information frame: polled RR or polled I
  function automatic logic info_grant(logic [1:0] kind, logic poll);
    return poll && (kind == RX_I || kind == RX_RR);
  endfunction

  // permission for a transparent frame: any I, or any polled supervisory
  function automatic logic transp_grant(logic [1:0] kind, logic poll);
    return (kind == RX_I) || poll;
  endfunction

  function automatic ack_e ack_class(logic [1:0] kind, seq_t nr, seq_t ns);
    if (kind == RX_REJ) return ACK_REP;
    if (nr == seq_next(ns)) return ACK_POS;
    if (nr == ns) return ACK_REP;
    return ACK_NONE;
  endfunction
endpackage

// File: rtl/sec_grant_decode.sv
module sec_grant_decode
  import sec_poll_pkg::*;
(
  input  logic       rx_valid,
  input  logic [1:0] rx_kind,
  input  logic       rx_poll,
  input  logic       pend_info,
  input  logic       pend_transp,
  output logic       go_info,
  output logic       go_transp,
  output logic       go_rresp
);
  always_comb begin
    go_info   = rx_valid && pend_info && info_grant(rx_kind, rx_poll);
    go_transp = rx_valid && !go_info && pend_transp && transp_grant(rx_kind, rx_poll);
    go_rresp  = rx_valid && rx_poll && !pend_info && !pend_transp;
  end
endmodule

// File: rtl/sec_ack_judge.sv
module sec_ack_judge
  import sec_poll_pkg::*;
(
  input  logic       awaiting,
  input  logic       rx_valid,
  input  logic [1:0] rx_kind,
  input  seq_t       rx_nr,
  input  seq_t       sent_ns,
  output logic       ack_pos,
  output logic       ack_rep
);
  ack_e verdict;
  always_comb begin
    verdict = ack_class(rx_kind, rx_nr, sent_ns);
    ack_pos = awaiting && rx_valid && (verdict == ACK_POS);
    ack_rep = awaiting && rx_valid && (verdict == ACK_REP);
  end
endmodule

// File: rtl/sec_recovery_timer.sv
module sec_recovery_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);
  logic             run_q;
  logic [TMR_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == limit);
  assign expire   = run_q && at_limit && !start && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (at_limit) run_q <= 1'b0;
      else          cnt_q <= cnt_q + TMR_W'(1);
    end
  end
endmodule

// File: rtl/sec_poll_tx_ctrl.sv
module sec_poll_tx_ctrl
  import sec_poll_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_send_info,
  input  logic             cmd_send_transp,
  input  logic             cmd_tx_reset,
  input  logic             cmd_tmr_start,
  input  logic             cmd_tmr_stop,
  input  logic [TMR_W-1:0] tmr_limit,
  input  logic             rx_valid,
  input  logic [1:0]       rx_kind,
  input  logic             rx_poll,
  input  logic [SEQ_W-1:0] rx_nr,
  input  logic             tx_done,
  output logic             tx_start,
  output logic [1:0]       tx_kind,
  output logic             tx_final,
  output logic [SEQ_W-1:0] tx_ns,
  output logic             fifo_en,
  output logic             irq_all_sent,
  output logic             irq_repeat,
  output logic             irq_timeout
);
  st_e  st_q;
  seq_t seq_q;
  logic pend_info_q, pend_transp_q;

  // named internal events
  logic go_info, go_transp, go_rresp;
  logic ack_pos, ack_rep, tmr_expire;
  logic in_idle, awaiting, ev_sent_info;

  assign in_idle      = (st_q == ST_IDLE);
  assign awaiting     = (st_q == ST_WAIT);
  assign ev_sent_info = (st_q == ST_SEND) && tx_done && (tx_kind == TX_INFO);
  assign fifo_en      = !((st_q == ST_WAIT) || (st_q == ST_STUCK));

  sec_grant_decode u_grant (
    .rx_valid    (rx_valid && in_idle),
    .rx_kind     (rx_kind),
    .rx_poll     (rx_poll),
    .pend_info   (pend_info_q),
    .pend_transp (pend_transp_q),
    .go_info     (go_info),
    .go_transp   (go_transp),
    .go_rresp    (go_rresp)
  );

  sec_ack_judge u_ack (
    .awaiting (awaiting),
    .rx_valid (rx_valid),
    .rx_kind  (rx_kind),
    .rx_nr    (rx_nr),
    .sent_ns  (seq_q),
    .ack_pos  (ack_pos),
    .ack_rep  (ack_rep)
  );

  sec_recovery_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cmd_tmr_start),
    .stop   (cmd_tmr_stop),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      seq_q         <= '0;
      pend_info_q   <= 1'b0;
      pend_transp_q <= 1'b0;
      tx_start      <= 1'b0;
      tx_kind       <= TX_INFO;
      tx_final      <= 1'b0;
      tx_ns         <= '0;
      irq_all_sent  <= 1'b0;
      irq_repeat    <= 1'b0;
      irq_timeout   <= 1'b0;
    end else begin
      tx_start     <= 1'b0;
      irq_all_sent <= 1'b0;
      irq_repeat   <= 1'b0;
      irq_timeout  <= 1'b0;
      if (cmd_send_info)   pend_info_q   <= 1'b1;
      if (cmd_send_transp) pend_transp_q <= 1'b1;

      if (cmd_tx_reset) begin
        st_q          <= ST_IDLE;
        pend_info_q   <= 1'b0;
        pend_transp_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (go_info) begin
              st_q     <= ST_SEND;
              tx_start <= 1'b1;
              tx_kind  <= TX_INFO;
              tx_final <= 1'b1;
              tx_ns    <= seq_q;
            end else if (go_transp) begin
              st_q          <= ST_SEND;
              tx_start      <= 1'b1;
              tx_kind       <= TX_TRANSP;
              tx_final      <= rx_poll;
              pend_transp_q <= 1'b0;
            end else if (go_rresp) begin
              st_q     <= ST_SEND;
              tx_start <= 1'b1;
              tx_kind  <= TX_RRESP;
              tx_final <= 1'b1;
            end
          end
          ST_SEND: begin
            if (tx_done) st_q <= (tx_kind == TX_INFO) ? ST_WAIT : ST_IDLE;
          end
          ST_WAIT: begin
            if (ack_pos) begin
              seq_q        <= seq_next(seq_q);
              pend_info_q  <= cmd_send_info;
              irq_all_sent <= 1'b1;
              st_q         <= ST_IDLE;
            end else if (ack_rep) begin
              irq_repeat <= 1'b1;
              st_q       <= ST_IDLE;
            end else if (tmr_expire) begin
              irq_timeout <= 1'b1;
              st_q        <= ST_STUCK;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_poll_tx_chk.sv
module sec_poll_tx_chk
  import sec_poll_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [1:0] rx_kind,
  input logic       rx_poll,
  input logic       tx_start,
  input logic [1:0] tx_kind,
  input logic       tx_final,
  input logic       fifo_en,
  input logic       irq_all_sent,
  input logic       irq_repeat,
  input logic       irq_timeout,
  input logic       ev_sent_info,
  input seq_t       seq_q,
  input logic       pend_info_q
);
  AST_NO_POLL_NO_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_kind == TX_INFO) |-> $past(rx_valid && rx_poll && (rx_kind == RX_I || rx_kind == RX_RR))); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R3
  AST_INFO_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_kind == TX_INFO) |-> tx_final); // R3
  AST_LOCK_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sent_info |=> !fifo_en); // R4
  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all_sent |-> (fifo_en && seq_q == seq_next($past(seq_q)))); // R5
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_all_sent, irq_repeat, irq_timeout})); // R5
  AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_repeat |-> (fifo_en && $stable(seq_q) && pend_info_q)); // R6
  AST_RRESP_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_kind == TX_RRESP) |-> (fifo_en && tx_final)); // R8
  AST_TIMEOUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> !fifo_en); // R9
  AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !tx_start); // R11
endmodule

bind sec_poll_tx_ctrl sec_poll_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_kind      (rx_kind),
  .rx_poll      (rx_poll),
  .tx_start     (tx_start),
  .tx_kind      (tx_kind),
  .tx_final     (tx_final),
  .fifo_en      (fifo_en),
  .irq_all_sent (irq_all_sent),
  .irq_repeat   (irq_repeat),
  .irq_timeout  (irq_timeout),
  .ev_sent_info (ev_sent_info),
  .seq_q        (seq_q),
  .pend_info_q  (pend_info_q)
);

// File: tb/sec_poll_tx_ctrl_test.sv
`timescale 1ns/1ps
module sec_poll_tx_ctrl_test;
  localparam int TW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic c_info = 0, c_transp = 0, c_rst = 0, c_tstart = 0, c_tstop = 0;
  logic [TW-1:0] limit = '0;
  logic rxv = 0, rxp = 0, txd = 0;
  logic [1:0] rxk = '0;
  logic [2:0] rxn = '0;
  logic tx_start, tx_final, fifo_en, irq_all, irq_rep, irq_to;
  logic [1:0] tx_kind;
  logic [2:0] tx_ns;
  int checks = 0, fails = 0;
  int m_seq = 0;
  bit m_pi = 0, m_pt = 0;

  always #2 clk = ~clk;

  sec_poll_tx_ctrl #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_send_info(c_info), .cmd_send_transp(c_transp),
    .cmd_tx_reset(c_rst), .cmd_tmr_start(c_tstart), .cmd_tmr_stop(c_tstop), .tmr_limit(limit),
    .rx_valid(rxv), .rx_kind(rxk), .rx_poll(rxp), .rx_nr(rxn), .tx_done(txd),
    .tx_start(tx_start), .tx_kind(tx_kind), .tx_final(tx_final), .tx_ns(tx_ns),
    .fifo_en(fifo_en), .irq_all_sent(irq_all), .irq_repeat(irq_rep), .irq_timeout(irq_to));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task automatic eq(string tag, int act, int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // 0 info,1 transp,2 txreset,3 tmr start,4 tmr stop
  task automatic cmd(int which);
    @(negedge clk);
    c_info = (which == 0); c_transp = (which == 1); c_rst = (which == 2);
    c_tstart = (which == 3); c_tstop = (which == 4);
    @(negedge clk);
    {c_info, c_transp, c_rst, c_tstart, c_tstop} = '0;
  endtask
  task automatic rx(int k, bit p, int nr);
    @(negedge clk);
    rxv = 1; rxk = 2'(k); rxp = p; rxn = 3'(nr);
    @(negedge clk);
    rxv = 0;
  endtask
  task automatic done();
    @(negedge clk); txd = 1;
    @(negedge clk); txd = 0;
  endtask

  // expected start for a grant frame: 0 info,1 transp,2 rr-resp,3 none
  function automatic int exp_start(bit pi, bit pt, int k, bit p);
    if (pi && p && (k == 0 || k == 1)) return 0;
    if (pt && (k == 0 || p)) return 1;
    if (p && !pi && !pt) return 2;
    return 3;
  endfunction

  initial begin
    #(4ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    eq("R1 fifo_en", fifo_en, 1); eq("R1 tx_start", tx_start, 0);
    eq("R1 irqs", {irq_all, irq_rep, irq_to}, 0);

    // R2: arming does not start
    cmd(0);
    n = 0;
    repeat (5) begin @(negedge clk); n += tx_start; end
    eq("R2 no start after arm", n, 0);
    rx(0, 0, 0); eq("R2 unpolled I", tx_start, 0);
    rx(1, 0, 0); eq("R2 unpolled RR", tx_start, 0);
    rx(2, 1, 0); eq("R3 polled REJ no info", tx_start, 0);
    rx(3, 1, 0); eq("R3 polled RNR no info", tx_start, 0);
    rx(1, 1, 0);
    eq("R3 start", tx_start, 1); eq("R3 kind", tx_kind, 0);
    eq("R3 final", tx_final, 1); eq("R3 ns", tx_ns, 0);
    @(negedge clk); eq("R3 one-cycle pulse", tx_start, 0);
    rx(1, 1, 0); eq("R11 grant while sending", tx_start, 0);
    done(); eq("R4 locked", fifo_en, 0);
    rx(1, 1, 5); eq("R11 odd nr ignored", fifo_en, 0);
    eq("R11 no irq", {irq_all, irq_rep}, 0); eq("R11 no start locked", tx_start, 0);
    rx(1, 0, 1); eq("R5 all_sent", irq_all, 1); eq("R5 fifo", fifo_en, 1);
    @(negedge clk); eq("R5 pulse", irq_all, 0);
    m_seq = 1;

    // R6 repeat
    cmd(0); rx(0, 1, 0); eq("R6 ns", tx_ns, 1); done();
    rx(2, 0, 2); eq("R6 rej repeat", irq_rep, 1); eq("R6 fifo", fifo_en, 1);
    rx(1, 1, 0); eq("R6 resend", tx_start, 1); eq("R6 same ns", tx_ns, 1); done();
    rx(1, 0, 1); eq("R6 nr==ns repeat", irq_rep, 1);
    rx(1, 1, 0); eq("R6 same ns again", tx_ns, 1); done();
    rx(0, 0, 2); eq("R5 ack via I", irq_all, 1);
    m_seq = 2;

    // R7 transparent
    cmd(1); rx(1, 0, 0); eq("R7 unpolled S no grant", tx_start, 0);
    rx(0, 0, 0); eq("R7 I grants", tx_start, 1); eq("R7 kind", tx_kind, 1);
    eq("R7 final=poll", tx_final, 0); done(); eq("R7 no lock", fifo_en, 1);
    cmd(1); rx(3, 1, 0); eq("R7 polled RNR", tx_kind, 1); eq("R7 final 1", tx_final, 1); done();

    // R8 RR response
    rx(1, 1, 0); eq("R8 rr resp", tx_kind, 2); eq("R8 start", tx_start, 1);
    eq("R8 final", tx_final, 1); done(); eq("R8 no lock", fifo_en, 1);

    // R7 priority
    cmd(0); cmd(1); rx(0, 1, 0); eq("R7 info priority", tx_kind, 0); done();
    rx(1, 0, 3); eq("R5 pos", irq_all, 1); m_seq = 3;
    rx(1, 1, 0); eq("R7 transp after", tx_kind, 1); done();

    // R9 timeout
    cmd(0); rx(1, 1, 0); done();
    limit = 5;
    cmd(3);
    n = 0;
    while (!irq_to && n < 100) begin @(negedge clk); n++; end
    eq("R9 expire cycle", n, 6); eq("R9 locked", fifo_en, 0);
    rx(1, 0, 4); eq("R9 ack ignored", irq_all, 0); eq("R9 still locked", fifo_en, 0);
    cmd(2); eq("R9 reset unlocks", fifo_en, 1);
    rx(1, 1, 0); eq("R9 pending dropped", tx_kind, 2); done();

    // R10 no self-start, stop works
    cmd(0); rx(1, 1, 0); eq("R10 ns", tx_ns, 3); done();
    n = 0;
    repeat (100) begin @(negedge clk); n += irq_to; end
    eq("R10 no timer", n, 0);
    cmd(3); cmd(4);
    repeat (20) begin @(negedge clk); n += irq_to; end
    eq("R10 stopped", n, 0); eq("R10 locked", fifo_en, 0);
    rx(1, 0, 4); eq("R5 pos", irq_all, 1); m_seq = 4;

    // random rounds
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 60; it++) begin
      int k, e, a, nr;
      bit p;
      if ($urandom_range(1)) begin cmd(0); m_pi = 1; end
      if ($urandom_range(1)) begin cmd(1); m_pt = 1; end
      k = $urandom_range(3); p = 1'($urandom_range(1));
      e = exp_start(m_pi, m_pt, k, p);
      rx(k, p, 0);
      if (e == 3) begin eq("R2 rand none", tx_start, 0); continue; end
      eq("R3 rand start", tx_start, 1); eq("R7 rand kind", tx_kind, e);
      if (e == 0) eq("R3 rand ns", tx_ns, m_seq);
      if (e == 1) m_pt = 0;
      done();
      if (e != 0) begin eq("R8 rand unlocked", fifo_en, 1); continue; end
      eq("R4 rand locked", fifo_en, 0);
      a = $urandom_range(2);
      if (a == 0) begin
        k = $urandom_range(2); if (k == 2) k = 3;
        rx(k, 0, (m_seq + 1) % 8);
        eq("R5 rand pos", irq_all, 1);
        m_seq = (m_seq + 1) % 8; m_pi = 0;
      end else begin
        nr = (a == 1) ? int'($urandom_range(7)) : m_seq;
        rx((a == 1) ? 2 : 1, 0, nr);
        eq("R6 rand rep", irq_rep, 1);
      end
      eq("R6 rand fifo", fifo_en, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule